// File: doc/BRIEF.md
# Per-CPU Inter-Processor Interrupt Unit

The block gives each CPU in a small cluster two doorbell interrupts. One class, "other", is raised by any CPU on a chosen set of targets. The second class, "self", is raised by a CPU on itself. Every CPU has its own register port. Through that port it can raise doorbells, acknowledge them, mask them, read which doorbell needs service, and learn its own index. Register accesses act either on the requesting CPU's own state (the current view) or on an explicitly addressed CPU's state (the per-CPU windows).

When a CPU reads its event register, it gets the highest-priority doorbell that is pending and unmasked, encoded as a type/number word. Reporting that doorbell also sets its mask bit, so the same doorbell is not reported again until software clears the mask. Each CPU's interrupt output is high while any of its doorbells is both pending and unmasked.

Top module: `ipi_unit`

## Requirements
- R1: After reset, every pending bit is clear and every mask bit is set. All `irq` outputs are low and all read data is zero.
- R2: A write of word W to offset 0x2008 does two things. For each bit c of W with c below NCPU, it raises "other" on CPU c. Bit 31 of W raises "self" on the writing CPU. Bits from NCPU to 30 are ignored.
- R3: `irq[c]` is high exactly when CPU c has a class that is both pending and unmasked.
- R4: A read of offset 0x2004 returns data on `bus_rdata` one cycle later. The value is 0x00040001 for "other", 0x00040002 for "self", and 0 when nothing is deliverable. "Other" is reported before "self". Unmapped reads return 0.
- R5: An event read that reports a class sets that class's mask bit. The other class's mask bit is left unchanged.
- R6: A write to offset 0x200C clears the writer's pending bits: bit 0 clears "other" and bit 31 clears "self". Mask bits are not affected.
- R7: Writes to offset 0x2024 set mask bits and writes to offset 0x2028 clear them. In both, bit 0 selects "other" and bit 31 selects "self".
- R8: The window for CPU c starts at 0x5000 + (c << 7). Within it, offset +0x08 raises, +0x0C clears, +0x24 sets the mask and +0x28 clears the mask, using the same bit 0 / bit 31 encoding. Windows for c ≥ NCPU are ignored.
- R9: A read of offset 0x2000 returns the index of the reading port one cycle later.
- R10: A raise and a clear of the same pending bit in the same cycle leave the bit set. An auto-mask and a mask clear of the same bit in the same cycle leave the mask set.
- R11: A pending bit stays set until it is cleared. Event reads and mask changes do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | NCPU | Per-port access strobe |
| bus_we | input | NCPU | Per-port write (1) or read (0) |
| bus_addr | input | NCPU*AW | Per-port byte address, port p at bits [p*AW +: AW] |
| bus_wdata | input | NCPU*32 | Per-port write data |
| bus_rdata | output | NCPU*32 | Per-port registered read data |
| irq | output | NCPU | Per-CPU interrupt request |

## Verification
Several properties are checked in every cycle. A coincident raise and clear must leave the pending bit set. Pending bits must only fall on a clear. A reported class must be masked the next cycle, and a lone mask clear must unmask. Event read data must take one of the three legal codes, and the index read must return the port number. Other behaviour can only be shown by the bench's scenarios. That covers the address decode of the current view and the per-CPU windows, the ignored send bits and out-of-range windows, the other-before-self order, and the interaction of two ports hitting the same CPU in one cycle.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
   localparam int DW        = 32;
   localparam int SELF_BIT  = 31;
   localparam int CLS_OTHER = 0;
   localparam int CLS_SELF  = 1;

   // current-CPU view offsets
   localparam int OFS_WHO   = 'h2000;
   localparam int OFS_EVT   = 'h2004;
   localparam int OFS_SEND  = 'h2008;
   localparam int OFS_ACK   = 'h200C;
   localparam int OFS_MSET  = 'h2024;
   localparam int OFS_MCLR  = 'h2028;

   // explicit per-CPU windows
   localparam int WIN_BASE   = 'h5000;
   localparam int WIN_SHIFT  = 7;
   localparam int WIN_STRIDE = 1 << WIN_SHIFT;
   localparam int WOFS_SET   = 'h08;
   localparam int WOFS_CLR   = 'h0C;
   localparam int WOFS_MSET  = 'h24;
   localparam int WOFS_MCLR  = 'h28;

   localparam logic [15:0] EVT_TYPE_IPI = 16'h0004;
   localparam logic [15:0] EVT_NUM_OTH  = 16'h0001;
   localparam logic [15:0] EVT_NUM_SLF  = 16'h0002;

   // bit 0: other, bit 1: self
   typedef logic [1:0] cls_t;

   typedef struct packed {
      cls_t set;
      cls_t clr;
      cls_t mset;
      cls_t mclr;
   } tgt_act_t;

   function automatic cls_t word_cls(input logic [DW-1:0] w);
      return {w[SELF_BIT], w[0]};
   endfunction
endpackage

// File: rtl/ipi_port_decode.sv
module ipi_port_decode
   import ipi_pkg::*;
#(
   parameter int NCPU = 4,
   parameter int AW   = 16,
   parameter int PORT = 0
) (
   input  logic                 req,
   input  logic                 we,
   input  logic [AW-1:0]        addr,
   input  logic [DW-1:0]        wdata,
   output tgt_act_t [NCPU-1:0]  act,
   output logic                 evt_rd,
   output logic                 who_rd
);
   localparam int WIN_END = WIN_BASE + NCPU * WIN_STRIDE;

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_comb begin
      int a_i;
      int idx;
      int off;
      act    = '0;
      evt_rd = 1'b0;
      who_rd = 1'b0;
      a_i    = int'(addr);
      idx    = (a_i - WIN_BASE) >>> WIN_SHIFT;
      off    = (a_i - WIN_BASE) & (WIN_STRIDE - 1);
      if (req && !we) begin
         evt_rd = (a_i == OFS_EVT);
         who_rd = (a_i == OFS_WHO);
      end
      if (req && we) begin
         case (a_i)
            OFS_SEND: begin
               for (int t = 0; t < NCPU; t++)
                  act[t].set[CLS_OTHER] = wdata[t];
               act[PORT].set[CLS_SELF] = wdata[SELF_BIT];
            end
            OFS_ACK:  act[PORT].clr  = word_cls(wdata);
            OFS_MSET: act[PORT].mset = word_cls(wdata);
            OFS_MCLR: act[PORT].mclr = word_cls(wdata);
            default: begin
               if (a_i >= WIN_BASE && a_i < WIN_END) begin
                  for (int t = 0; t < NCPU; t++) begin
                     if (idx == t) begin
                        case (off)
                           WOFS_SET:  act[t].set  = word_cls(wdata);
                           WOFS_CLR:  act[t].clr  = word_cls(wdata);
                           WOFS_MSET: act[t].mset = word_cls(wdata);
                           WOFS_MCLR: act[t].mclr = word_cls(wdata);
                           default: ;
                        endcase
                     end
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/ipi_cpu_state.sv
module ipi_cpu_state
   import ipi_pkg::*;
#(
   parameter int NCPU = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  tgt_act_t [NCPU-1:0]  acts,
   input  logic                 evt_rd,
   output logic [DW-1:0]        evt_word,
   output logic                 irq
);
   cls_t pend_q, mask_q;
   cls_t set_any, clr_any, mset_any, mclr_any;
   cls_t deliver, pick, auto_m;

   always_comb begin
      set_any  = '0;
      clr_any  = '0;
      mset_any = '0;
      mclr_any = '0;
      for (int p = 0; p < NCPU; p++) begin
         set_any  = set_any  | acts[p].set;
         clr_any  = clr_any  | acts[p].clr;
         mset_any = mset_any | acts[p].mset;
         mclr_any = mclr_any | acts[p].mclr;
      end
   end

   assign deliver = pend_q & ~mask_q;
   // fixed order: other ahead of self
   assign pick    = deliver[CLS_OTHER] ? 2'b01 : (deliver[CLS_SELF] ? 2'b10 : 2'b00);
   assign auto_m  = evt_rd ? pick : 2'b00;

   always_comb begin
      unique case (pick)
         2'b01:   evt_word = {EVT_TYPE_IPI, EVT_NUM_OTH};
         2'b10:   evt_word = {EVT_TYPE_IPI, EVT_NUM_SLF};
         default: evt_word = '0;
      endcase
   end

   assign irq = |deliver;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '1;
      end else begin
         pend_q <= (pend_q & ~clr_any) | set_any;
         mask_q <= (mask_q & ~mclr_any) | mset_any | auto_m;
      end
   end

   for (genvar k = 0; k < 2; k++) begin : g_cls_chk
      p_send_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (set_any[k] && clr_any[k]) |=> pend_q[k]);
      p_pend_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_q[k] && !clr_any[k]) |=> pend_q[k]);
      p_unmask_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (mclr_any[k] && !mset_any[k] && !auto_m[k]) |=> !mask_q[k]);
   end

   p_automask_oth_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_rd && deliver[CLS_OTHER]) |=> mask_q[CLS_OTHER]);
   p_automask_slf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_rd && deliver[CLS_SELF] && !deliver[CLS_OTHER]) |=> mask_q[CLS_SELF]);
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
   import ipi_pkg::*;
#(
   parameter int NCPU = 4,
   parameter int AW   = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NCPU-1:0]      bus_req,
   input  logic [NCPU-1:0]      bus_we,
   input  logic [NCPU*AW-1:0]   bus_addr,
   input  logic [NCPU*DW-1:0]   bus_wdata,
   output logic [NCPU*DW-1:0]   bus_rdata,
   output logic [NCPU-1:0]      irq
);
   initial begin
      assert (NCPU >= 1 && NCPU <= SELF_BIT)
         else $error("ipi_unit: NCPU must be 1..31");
      assert (AW >= 15 && AW <= 31)
         else $error("ipi_unit: AW must be 15..31");
   end

   tgt_act_t [NCPU-1:0] act_pt [NCPU];  // [port][target]
   tgt_act_t [NCPU-1:0] act_tp [NCPU];  // [target][port]
   logic [NCPU-1:0]     evt_rd, who_rd;
   logic [DW-1:0]       evt_word [NCPU];
   logic [DW-1:0]       rd_q     [NCPU];

   always_comb begin
      for (int t = 0; t < NCPU; t++)
         for (int p = 0; p < NCPU; p++)
            act_tp[t][p] = act_pt[p][t];
   end

   for (genvar p = 0; p < NCPU; p++) begin : g_port
      ipi_port_decode #(.NCPU(NCPU), .AW(AW), .PORT(p)) u_dec (
         .req    (bus_req[p]),
         .we     (bus_we[p]),
         .addr   (bus_addr[p*AW +: AW]),
         .wdata  (bus_wdata[p*DW +: DW]),
         .act    (act_pt[p]),
         .evt_rd (evt_rd[p]),
         .who_rd (who_rd[p])
      );

      ipi_cpu_state #(.NCPU(NCPU)) u_state (
         .clk      (clk),
         .rst_n    (rst_n),
         .acts     (act_tp[p]),
         .evt_rd   (evt_rd[p]),
         .evt_word (evt_word[p]),
         .irq      (irq[p])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rd_q[p] <= '0;
         else if (bus_req[p] && !bus_we[p])
            rd_q[p] <= who_rd[p] ? DW'(p) : (evt_rd[p] ? evt_word[p] : '0);
      end

      assign bus_rdata[p*DW +: DW] = rd_q[p];

      p_who_r9: assert property (@(posedge clk) disable iff (!rst_n)
         who_rd[p] |=> (bus_rdata[p*DW +: DW] == DW'(p)));
      p_evt_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
         evt_rd[p] |=> (bus_rdata[p*DW +: DW] == '0 ||
                        bus_rdata[p*DW +: DW] == {EVT_TYPE_IPI, EVT_NUM_OTH} ||
                        bus_rdata[p*DW +: DW] == {EVT_TYPE_IPI, EVT_NUM_SLF}));
   end
endmodule

// File: tb/ipi_unit_test.sv
module ipi_unit_test;
   localparam int N  = 4;
   localparam int AW = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N-1:0]      req = '0;
   logic [N-1:0]      we = '0;
   logic [N*AW-1:0]   addr = '0;
   logic [N*32-1:0]   wdata = '0;
   logic [N*32-1:0]   rdata;
   logic [N-1:0]      irq;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   ipi_unit #(.NCPU(N), .AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
   );

   // {port[2], rd[1], addr[16], wdata[32], exp_rd[32], exp_irq[4], rq[4]}
   localparam int NT = 30;
   localparam logic [90:0] TBL [NT] = '{
      {2'd0,1'b1,16'h2004,32'h0,        32'h0,        4'b0000,4'd4},  // R4 nothing
      {2'd0,1'b0,16'h2008,32'h2,        32'h0,        4'b0000,4'd1},  // R1 mask after reset
      {2'd1,1'b0,16'h2028,32'h1,        32'h0,        4'b0010,4'd7},  // R7
      {2'd1,1'b1,16'h2004,32'h0,        32'h00040001, 4'b0000,4'd5},  // R5
      {2'd1,1'b1,16'h2004,32'h0,        32'h0,        4'b0000,4'd5},  // R5
      {2'd1,1'b0,16'h2028,32'h1,        32'h0,        4'b0010,4'd11}, // R11
      {2'd1,1'b0,16'h200C,32'h1,        32'h0,        4'b0000,4'd6},  // R6
      {2'd0,1'b0,16'h2008,32'h2,        32'h0,        4'b0010,4'd6},  // R6 mask kept
      {2'd1,1'b0,16'h200C,32'h1,        32'h0,        4'b0000,4'd6},  // R6
      {2'd2,1'b0,16'h2008,32'h80000000, 32'h0,        4'b0000,4'd2},  // R2 self
      {2'd2,1'b0,16'h2008,32'h4,        32'h0,        4'b0000,4'd2},  // R2
      {2'd2,1'b0,16'h2028,32'h80000001, 32'h0,        4'b0100,4'd7},  // R7
      {2'd2,1'b1,16'h2004,32'h0,        32'h00040001, 4'b0100,4'd4},  // R4 other first
      {2'd2,1'b1,16'h2004,32'h0,        32'h00040002, 4'b0000,4'd4},  // R4
      {2'd2,1'b1,16'h2004,32'h0,        32'h0,        4'b0000,4'd4},  // R4
      {2'd2,1'b0,16'h200C,32'h80000001, 32'h0,        4'b0000,4'd6},  // R6
      {2'd2,1'b0,16'h2028,32'h80000001, 32'h0,        4'b0000,4'd3},  // R3
      {2'd3,1'b0,16'h5108,32'h80000000, 32'h0,        4'b0100,4'd8},  // R8
      {2'd0,1'b0,16'h510C,32'h80000000, 32'h0,        4'b0000,4'd8},  // R8
      {2'd0,1'b0,16'h5124,32'h1,        32'h0,        4'b0000,4'd8},  // R8
      {2'd0,1'b0,16'h5108,32'h1,        32'h0,        4'b0000,4'd8},  // R8
      {2'd0,1'b0,16'h5128,32'h1,        32'h0,        4'b0100,4'd8},  // R8
      {2'd0,1'b0,16'h2008,32'h30,       32'h0,        4'b0100,4'd2},  // R2 high bits
      {2'd0,1'b0,16'h5208,32'hFFFFFFFF, 32'h0,        4'b0100,4'd8},  // R8 no cpu 4
      {2'd3,1'b1,16'h2000,32'h0,        32'h3,        4'b0100,4'd9},  // R9
      {2'd1,1'b1,16'h2000,32'h0,        32'h1,        4'b0100,4'd9},  // R9
      {2'd2,1'b0,16'h2024,32'h1,        32'h0,        4'b0000,4'd7},  // R7
      {2'd2,1'b1,16'h2004,32'h0,        32'h0,        4'b0000,4'd4},  // R4 masked
      {2'd2,1'b1,16'h2010,32'h0,        32'h0,        4'b0000,4'd4},  // R4 unmapped
      {2'd2,1'b0,16'h2028,32'h1,        32'h0,        4'b0100,4'd11}  // R11
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input int p, input logic rd, input logic [15:0] a, input logic [31:0] d);
      req[p] = 1'b1;
      we[p]  = !rd;
      addr[p*AW +: AW] = a;
      wdata[p*32 +: 32] = d;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      req = '0;
      we  = '0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 irq in reset", {28'd0, irq}, 32'h0);
      for (int p = 0; p < N; p++) chk("R1 rdata in reset", rdata[p*32 +: 32], 32'h0);
      rst_n = 1'b1;
      tick();

      for (int i = 0; i < NT; i++) begin
         logic [90:0] e;
         string tg;
         e = TBL[i];
         tg = $sformatf("R%0d step %0d", e[3:0], i);
         idle();
         drive(int'(e[90:89]), e[88], e[87:72], e[71:40]);
         tick();
         if (e[88]) chk({tg, " rdata"}, rdata[int'(e[90:89])*32 +: 32], e[39:8]);
         chk({tg, " irq"}, {28'd0, irq}, {28'd0, e[7:4]});
      end
      idle();

      // R10: raise from port 1 and clear from port 2 hit cpu2 other together
      drive(2, 1'b0, 16'h200C, 32'h1);
      drive(1, 1'b0, 16'h2008, 32'h4);
      tick();
      idle();
      chk("R10 send beats ack irq", {28'd0, irq}, 32'h4);

      // R10: auto-mask and a mask clear on cpu2 other together
      drive(2, 1'b1, 16'h2004, 32'h0);
      drive(0, 1'b0, 16'h5128, 32'h1);
      tick();
      idle();
      chk("R10 event code", rdata[2*32 +: 32], 32'h00040001);
      chk("R10 auto-mask kept irq", {28'd0, irq}, 32'h0);

      // R1: a second reset clears pending and restores masks
      rst_n = 1'b0;
      tick();
      chk("R1 irq after reset", {28'd0, irq}, 32'h0);
      chk("R1 rdata after reset", rdata[2*32 +: 32], 32'h0);
      rst_n = 1'b1;
      tick();
      drive(2, 1'b0, 16'h2028, 32'h80000001);
      tick();
      idle();
      chk("R1 no pending after reset", {28'd0, irq}, 32'h0);
      drive(0, 1'b0, 16'h2008, 32'h1);
      tick();
      idle();
      chk("R1 cpu0 masked after reset", {28'd0, irq}, 32'h0);

      summary();
      $finish;
   end
endmodule